// File: doc/BRIEF.md
# Receive Flow Control with Hysteresis

This block watches the fill count of a 64-entry receive FIFO and drives the active-low RTS request output to the far-end transmitter. The RTS output does not toggle at one threshold. It goes high (stop sending) when the count climbs to an upper limit. It goes low again (resume) only after the FIFO has drained to a lower limit. The two limits sit on either side of the receive-data interrupt trigger, so the local host is interrupted before the far end is throttled. Data keeps arriving after RTS goes high, up to the FIFO's full count. The FIFO itself, the serial receiver, the baud clock and the register decode are outside the block; the block only reads the count.

The trigger and the two limits come from one of two sources. In programmable mode, a trigger and a gap are written, and the limits are the trigger plus and minus the gap. In one of three fixed-table modes, a 2-bit index picks a trigger from a table of four levels, and the limits are the neighbouring table entries. Automatic control starts only after software has enabled it and then requested RTS on. An optional flag reports every low-to-high transition of the RTS pin.

Top module: `rx_flow_hyst`

## Requirements
- R1: Automatic control is active only while `auto_en` and `sw_rts_req` are both 1. On the first active cycle, RTS is driven low unless the count is already at or above the upper limit, in which case it is driven high.
- R2: `rx_irq` is 1 one cycle after any cycle in which `fifo_count` is greater than or equal to the active trigger level, and 0 otherwise.
- R3: While automatic control is active, a count at or above the upper limit drives `rts_n` to 1 one cycle later. A count strictly between the two limits leaves `rts_n` unchanged.
- R4: While automatic control is active and `rts_n` is 1, it returns to 0 one cycle after the count is at or below the lower limit, and not before.
- R5: With `trig_mode` = 0 (programmable), the trigger is `prog_trig`. The upper limit is `prog_trig + prog_hyst`, capped at the FIFO depth of 64. The lower limit is `prog_trig - prog_hyst`, floored at 0.
- R6: With `trig_mode` 1, 2 and 3, `trig_sel` (0..3) picks a trigger from the tables {1,4,8,14}, {8,16,24,28} and {8,16,32,56}. The upper limit is the next higher entry (64 beyond the last entry). The lower limit is the next lower entry (0 below the first entry).
- R7: When `flow_irq_en` is 1, a 0-to-1 transition of `rts_n` sets `flow_irq` in the same cycle that `rts_n` rises. When `flow_irq_en` is 0, the transition leaves `flow_irq` unchanged.
- R8: `flow_irq` stays set until `status_rd` is 1 at a clock edge, which clears it. If a qualifying RTS rising edge occurs at that same edge, the flag stays set.
- R9: While automatic control is inactive, `rts_n` equals the inverse of `sw_rts_req`, one cycle later.
- R10: Asynchronous reset (`rst_n` low) forces `rts_n` to 1 and both `rx_irq` and `flow_irq` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_count | input | 7 | Receive FIFO entries in use, 0..64 |
| trig_mode | input | 2 | 0 programmable, 1..3 fixed tables |
| trig_sel | input | 2 | Table entry index in fixed modes |
| prog_trig | input | 7 | Programmable trigger level |
| prog_hyst | input | 7 | Programmable hysteresis gap |
| auto_en | input | 1 | Automatic RTS control enable |
| sw_rts_req | input | 1 | Software RTS request, 1 means RTS on (pin low) |
| flow_irq_en | input | 1 | Enable for the RTS-edge flag |
| status_rd | input | 1 | Status read strobe, clears `flow_irq` |
| rts_n | output | 1 | Active-low request-to-send output |
| rx_irq | output | 1 | Receive trigger reached |
| flow_irq | output | 1 | RTS rose from low to high |

## Verification
The bench builds the block with its default depth of 64 and with the fixed tables included. This makes the capped upper limit of 64 and the floored lower limit of 0 reachable in programmable mode. It also makes the first and last entries of each table, where a neighbour is missing, reachable in fixed mode. The vector walk crosses each limit one count short of it and then exactly on it. It also starts automatic control with the count both below and above the upper limit, and coincides a status read with an RTS rising edge.

// File: rtl/rxfc_pkg.sv
package rxfc_pkg;

   localparam int unsigned NUM_LVLS = 4;

   typedef enum logic [1:0] {
      TRIG_PROG  = 2'd0,
      TRIG_TAB_A = 2'd1,
      TRIG_TAB_B = 2'd2,
      TRIG_TAB_C = 2'd3
   } trig_mode_e;

   // Fixed trigger tables, four ascending levels each.
   function automatic logic [6:0] tab_lvl(input logic [1:0] mode, input logic [1:0] idx);
      logic [6:0] v;
      v = 7'd0;
      unique case (trig_mode_e'(mode))
         TRIG_TAB_A: case (idx) 2'd0: v = 7'd1; 2'd1: v = 7'd4;  2'd2: v = 7'd8;  default: v = 7'd14; endcase
         TRIG_TAB_B: case (idx) 2'd0: v = 7'd8; 2'd1: v = 7'd16; 2'd2: v = 7'd24; default: v = 7'd28; endcase
         TRIG_TAB_C: case (idx) 2'd0: v = 7'd8; 2'd1: v = 7'd16; 2'd2: v = 7'd32; default: v = 7'd56; endcase
         default:    v = 7'd0;
      endcase
      return v;
   endfunction

endpackage

// File: rtl/rxfc_thresholds.sv
module rxfc_thresholds
   import rxfc_pkg::*;
#(
   parameter int unsigned DEPTH      = 64,
   parameter bit          USE_TABLES = 1'b1,
   localparam int unsigned CW        = $clog2(DEPTH + 1)
) (
   input  logic [1:0]    trig_mode,
   input  logic [1:0]    trig_sel,
   input  logic [CW-1:0] prog_trig,
   input  logic [CW-1:0] prog_hyst,
   output logic [CW-1:0] trig_lvl,
   output logic [CW-1:0] upper_lim,
   output logic [CW-1:0] lower_lim
);

   localparam logic [CW:0]   FULL_X = (CW+1)'(DEPTH);
   localparam logic [CW-1:0] FULL   = CW'(DEPTH);

   // Programmable limits, capped at full and floored at zero.
   logic [CW:0]   sum_x;
   logic [CW-1:0] p_upper, p_lower;

   always_comb begin
      sum_x   = {1'b0, prog_trig} + {1'b0, prog_hyst};
      p_upper = (sum_x > FULL_X) ? FULL : sum_x[CW-1:0];
      p_lower = (prog_trig > prog_hyst) ? (prog_trig - prog_hyst) : '0;
   end

   generate
      if (USE_TABLES) begin : g_tables
         logic [CW-1:0] t_trig, t_upper, t_lower;

         always_comb begin
            t_trig  = CW'(tab_lvl(trig_mode, trig_sel));
            t_upper = (trig_sel == 2'(NUM_LVLS - 1)) ? FULL
                                                     : CW'(tab_lvl(trig_mode, trig_sel + 2'd1));
            t_lower = (trig_sel == 2'd0) ? '0
                                         : CW'(tab_lvl(trig_mode, trig_sel - 2'd1));
            if (trig_mode == TRIG_PROG) begin
               trig_lvl  = prog_trig;
               upper_lim = p_upper;
               lower_lim = p_lower;
            end else begin
               trig_lvl  = t_trig;
               upper_lim = t_upper;
               lower_lim = t_lower;
            end
         end
      end else begin : g_prog_only
         logic unused_sel;
         assign unused_sel = ^{trig_mode, trig_sel};
         assign trig_lvl   = prog_trig;
         assign upper_lim  = p_upper;
         assign lower_lim  = p_lower;
      end
   endgenerate

endmodule

// File: rtl/rxfc_rts_ctrl.sv
module rxfc_rts_ctrl #(
   parameter int unsigned CW = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          auto_en,
   input  logic          sw_rts_req,
   input  logic [CW-1:0] fifo_count,
   input  logic [CW-1:0] upper_lim,
   input  logic [CW-1:0] lower_lim,
   output logic          rts_n,
   output logic          rts_rise
);

   logic act, act_q, rts_q, rts_next;

   assign act = auto_en & sw_rts_req;

   always_comb begin
      if (!act)                        rts_next = ~sw_rts_req;
      else if (fifo_count >= upper_lim) rts_next = 1'b1;
      else if (!act_q)                 rts_next = 1'b0;
      else if (fifo_count <= lower_lim) rts_next = 1'b0;
      else                             rts_next = rts_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rts_q <= 1'b1;
         act_q <= 1'b0;
      end else begin
         rts_q <= rts_next;
         act_q <= act;
      end
   end

   assign rts_n    = rts_q;
   assign rts_rise = rts_next & ~rts_q;

endmodule

// File: rtl/rxfc_irq_flags.sv
module rxfc_irq_flags #(
   parameter int unsigned CW = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] fifo_count,
   input  logic [CW-1:0] trig_lvl,
   input  logic          rts_rise,
   input  logic          flow_irq_en,
   input  logic          status_rd,
   output logic          rx_irq,
   output logic          flow_irq
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_irq   <= 1'b0;
         flow_irq <= 1'b0;
      end else begin
         rx_irq <= (fifo_count >= trig_lvl);
         if (flow_irq_en && rts_rise) flow_irq <= 1'b1;
         else if (status_rd)          flow_irq <= 1'b0;
      end
   end

endmodule

// File: rtl/rx_flow_hyst.sv
module rx_flow_hyst #(
   parameter int unsigned DEPTH      = 64,
   parameter bit          USE_TABLES = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [6:0] fifo_count,
   input  logic [1:0] trig_mode,
   input  logic [1:0] trig_sel,
   input  logic [6:0] prog_trig,
   input  logic [6:0] prog_hyst,
   input  logic       auto_en,
   input  logic       sw_rts_req,
   input  logic       flow_irq_en,
   input  logic       status_rd,
   output logic       rts_n,
   output logic       rx_irq,
   output logic       flow_irq
);

   localparam int unsigned CNT_W = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 4 || DEPTH > 64) begin : g_bad_depth
         $error("rx_flow_hyst: DEPTH must lie in 4..64 for a 7-bit count");
      end
      if (USE_TABLES && DEPTH != 64) begin : g_bad_tables
         $error("rx_flow_hyst: fixed tables assume a 64-entry FIFO");
      end
   endgenerate

   logic [CNT_W-1:0] trig_lvl, upper_lim, lower_lim;
   logic             rts_rise;

   rxfc_thresholds #(.DEPTH(DEPTH), .USE_TABLES(USE_TABLES)) i_thr (
      .trig_mode (trig_mode),
      .trig_sel  (trig_sel),
      .prog_trig (CNT_W'(prog_trig)),
      .prog_hyst (CNT_W'(prog_hyst)),
      .trig_lvl  (trig_lvl),
      .upper_lim (upper_lim),
      .lower_lim (lower_lim)
   );

   rxfc_rts_ctrl #(.CW(CNT_W)) i_rts (
      .clk        (clk),
      .rst_n      (rst_n),
      .auto_en    (auto_en),
      .sw_rts_req (sw_rts_req),
      .fifo_count (CNT_W'(fifo_count)),
      .upper_lim  (upper_lim),
      .lower_lim  (lower_lim),
      .rts_n      (rts_n),
      .rts_rise   (rts_rise)
   );

   rxfc_irq_flags #(.CW(CNT_W)) i_irq (
      .clk         (clk),
      .rst_n       (rst_n),
      .fifo_count  (CNT_W'(fifo_count)),
      .trig_lvl    (trig_lvl),
      .rts_rise    (rts_rise),
      .flow_irq_en (flow_irq_en),
      .status_rd   (status_rd),
      .rx_irq      (rx_irq),
      .flow_irq    (flow_irq)
   );

endmodule

// File: rtl/rx_flow_hyst_chk.sv
module rx_flow_hyst_chk #(
   parameter int unsigned CW = 7
) (
   input logic          clk,
   input logic          rst_n,
   input logic          auto_en,
   input logic          sw_rts_req,
   input logic          flow_irq_en,
   input logic          status_rd,
   input logic [6:0]    fifo_count,
   input logic          rts_n,
   input logic          rx_irq,
   input logic          flow_irq,
   input logic [CW-1:0] trig_lvl,
   input logic [CW-1:0] upper_lim,
   input logic [CW-1:0] lower_lim
);

   logic active;
   assign active = auto_en & sw_rts_req;

   // R2
   rx_trigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (rx_irq == $past(CW'(fifo_count) >= trig_lvl)));

   // R3
   upper_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && CW'(fifo_count) >= upper_lim) |=> rts_n);

   // R4
   lower_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && CW'(fifo_count) <= lower_lim && CW'(fifo_count) < upper_lim) |=> !rts_n);

   // R3
   band_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && $past(active) && CW'(fifo_count) > lower_lim && CW'(fifo_count) < upper_lim)
      |=> $stable(rts_n));

   // R9
   sw_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> (rts_n == !$past(sw_rts_req)));

   // R7
   edge_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flow_irq_en && !rts_n) |=> (rts_n -> flow_irq));

   // R8
   read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      status_rd |=> ($rose(rts_n) || !flow_irq));

endmodule

bind rx_flow_hyst rx_flow_hyst_chk #(.CW(CNT_W)) i_chk (.*);

// File: tb/test_rx_flow_hyst.sv
module test_rx_flow_hyst;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [6:0] fifo_count = '0;
   logic [1:0] trig_mode = '0, trig_sel = '0;
   logic [6:0] prog_trig = 7'd16, prog_hyst = 7'd8;
   logic       auto_en = 1'b0, sw_rts_req = 1'b0, flow_irq_en = 1'b0, status_rd = 1'b0;
   logic       rts_n, rx_irq, flow_irq;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   rx_flow_hyst i_rx_flow_hyst (.*);

   typedef struct packed {
      logic       ae, sw, fe, rd;
      logic [1:0] mode, sel;
      logic [6:0] trig, hyst, cnt;
      logic       e_rts, e_rx, e_fl;
      logic [3:0] rq;
   } vec_t;

   localparam int NV = 36;
   // ae sw fe rd mode sel trig hyst cnt | rts rx fl | requirement on rts
   localparam vec_t VECS [NV] = '{
      '{1,0,1,0, 0,0, 16, 8,  0, 1,0,0,  9}, // R9 not started yet
      '{1,1,1,0, 0,0, 16, 8,  0, 0,0,0,  1}, // R1 start, below upper
      '{1,1,1,0, 0,0, 16, 8, 16, 0,1,0,  3}, // R2 trigger reached, R3 in band
      '{1,1,1,0, 0,0, 16, 8, 23, 0,1,0,  3}, // R3 one below upper
      '{1,1,1,0, 0,0, 16, 8, 24, 1,1,1,  7}, // R3 upper, R7 flag
      '{1,1,1,0, 0,0, 16, 8, 30, 1,1,1,  8}, // R8 flag held
      '{1,1,1,1, 0,0, 16, 8, 12, 1,0,0,  8}, // R8 read clears, R4 band
      '{1,1,1,0, 0,0, 16, 8,  9, 1,0,0,  4}, // R4 one above lower
      '{1,1,1,0, 0,0, 16, 8,  8, 0,0,0,  4}, // R4 at lower
      '{1,1,1,0, 0,0, 16, 8, 20, 0,1,0,  3}, // R3 hold low in band
      '{1,1,1,1, 0,0, 16, 8, 64, 1,1,1,  8}, // R8 set wins over read
      '{1,1,1,0, 0,0, 16, 8, 64, 1,1,1,  5}, // R5 full FIFO
      '{0,1,1,1, 0,0, 16, 8, 64, 0,1,0,  9}, // R9 software on
      '{0,0,0,0, 0,0, 16, 8,  0, 1,0,0,  7}, // R7 rise with flag disabled
      '{1,1,0,0, 2,2,  0, 0, 20, 0,0,0,  6}, // R6 table 2 idx2: 24/28/16
      '{1,1,0,0, 2,2,  0, 0, 27, 0,1,0,  6}, // R6
      '{1,1,0,0, 2,2,  0, 0, 28, 1,1,0,  6}, // R6 upper = next entry
      '{1,1,0,0, 2,2,  0, 0, 17, 1,0,0,  6}, // R6
      '{1,1,0,0, 2,2,  0, 0, 16, 0,0,0,  6}, // R6 lower = previous entry
      '{1,1,0,0, 1,3,  0, 0, 63, 0,1,0,  6}, // R6 table 1 last: upper 64
      '{1,1,0,0, 1,3,  0, 0, 64, 1,1,0,  6}, // R6
      '{1,1,0,0, 1,3,  0, 0,  8, 0,0,0,  6}, // R6 lower 8
      '{1,1,0,0, 0,0, 60,10, 63, 0,1,0,  5}, // R5 upper capped at 64
      '{1,1,0,0, 0,0, 60,10, 64, 1,1,0,  5}, // R5
      '{1,1,0,0, 0,0, 60,10, 51, 1,0,0,  5}, // R5
      '{1,1,0,0, 0,0, 60,10, 50, 0,0,0,  5}, // R5 lower 50
      '{1,1,0,0, 0,0,  4,10, 14, 1,1,0,  5}, // R5 upper 14
      '{1,1,0,0, 0,0,  4,10,  1, 1,0,0,  5}, // R5 lower floored at 0
      '{1,1,0,0, 0,0,  4,10,  0, 0,0,0,  5}, // R5
      '{1,0,0,0, 0,0,  4,10, 20, 1,1,0,  9}, // R9 off by software
      '{1,1,0,0, 0,0,  4,10, 20, 1,1,0,  1}, // R1 start above upper
      '{1,1,0,0, 0,0,  4,10, 10, 1,1,0,  1}, // R1 stays high in band
      '{1,1,0,0, 1,0,  0, 0,  4, 1,1,0,  6}, // R6 table 1 first: upper 4
      '{1,1,0,0, 1,0,  0, 0,  0, 0,0,0,  6}, // R6 lower 0
      '{1,1,0,0, 3,2,  0, 0, 55, 0,1,0,  6}, // R6 table 3 idx2: upper 56
      '{1,1,0,0, 3,2,  0, 0, 56, 1,1,0,  6}  // R6
   };

   task automatic check(input string req, input string what, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
      end
   endtask

   task automatic apply(input vec_t v);
      auto_en = v.ae; sw_rts_req = v.sw; flow_irq_en = v.fe; status_rd = v.rd;
      trig_mode = v.mode; trig_sel = v.sel; prog_trig = v.trig; prog_hyst = v.hyst;
      fifo_count = v.cnt;
   endtask

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state
      check("R10", "rts_n", rts_n, 1'b1);
      check("R10", "rx_irq", rx_irq, 1'b0);
      check("R10", "flow_irq", flow_irq, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         apply(VECS[i]);
         @(posedge clk);
         @(negedge clk);
         check($sformatf("R%0d vec%0d", VECS[i].rq, i), "rts_n", rts_n, VECS[i].e_rts);
         check($sformatf("R2 vec%0d", i), "rx_irq", rx_irq, VECS[i].e_rx);
         check($sformatf("R7/R8 vec%0d", i), "flow_irq", flow_irq, VECS[i].e_fl);
      end

      // Directed: build up flags, then R10 asynchronous reset mid-run
      apply('{1,1,1,0, 0,0, 16,8, 0, 0,0,0, 10});
      @(posedge clk); @(negedge clk);
      check("R4", "rts_n low at 0", rts_n, 1'b0);
      fifo_count = 7'd40;
      @(posedge clk); @(negedge clk);
      check("R7", "flow_irq set", flow_irq, 1'b1);
      check("R2", "rx_irq set", rx_irq, 1'b1);
      rst_n = 1'b0;
      #1;
      check("R10", "rts_n after reset", rts_n, 1'b1);
      check("R10", "rx_irq after reset", rx_irq, 1'b0);
      check("R10", "flow_irq after reset", flow_irq, 1'b0);
      @(negedge clk);
      apply('{0,0,0,0, 0,0, 16,8, 0, 1,0,0, 9});
      rst_n = 1'b1;
      @(posedge clk); @(negedge clk);
      check("R9", "rts_n idle", rts_n, 1'b1);

      done = 1'b1;
      finish_run();
   end

endmodule